// File: doc/BRIEF.md
# Low-Speed USB Line Receiver

This block watches the two data lines of a low-speed USB link and turns the traffic on them into packet bytes. A free-running oversample clock runs at a fixed multiple of the bit rate. A phase counter that restarts on every level change on D- sets the bit centres. The receiver first waits for the idle (J) level. It then locks onto the first J-to-K edge and confirms the end of the sync field when it sees two K bits in a row. After that it decodes NRZI, removes stuffed bits and packs bits into bytes, least significant bit first, until the single-ended-zero end-of-packet appears.

Bytes come out on a simple strobe interface: `rx_valid` marks a byte and `rx_last` marks the final byte of the packet. At the end of every packet a one-cycle `pkt_done` strobe reports the byte count and three outcome flags: short handshake-class packet, overflow, and stuffing violation. The receiver holds the two most recent bytes back inside the block. Because of this, a packet shorter than three bytes never puts a byte on the output. PID decoding, address matching and CRC checking belong to the logic downstream.

Top module: `lsusb_rx`

## Requirements
- R1: With the line idle at J (D- high, D+ low), a J-to-K edge followed by the line pattern K J K J K J K K (sync, data value 0x80 sent LSB first) starts packet reception. The first data bit is the one after the second of the two final K bits.
- R2: If a K bit in the sync search is followed by a J bit instead of a second K, the receiver drops the attempt and hunts for the next J-to-K edge. A valid sync that follows is then received normally.
- R3: A bit whose level equals the previous bit's level decodes as 1, and a level change decodes as 0. Bits fill each byte from bit 0 upward.
- R4: After six consecutive decoded 1 bits, counting the final 1 of the sync field, the next bit is discarded and not placed in any byte.
- R5: If that discarded position shows no level change, the packet is dropped. `pkt_done` pulses with `pkt_stuff_err` high and `pkt_len` equal to the bytes completed so far, and nothing more is emitted until the line has shown SE0.
- R6: SE0 (both lines low) seen at any bit position other than the first of a byte ends the packet. At the first position it is decoded as an ordinary bit, so one dribbled bit before SE0 is tolerated. Incomplete bits are dropped.
- R7: For a packet of three or more bytes, every byte appears once on `rx_byte` with `rx_valid` in arrival order. The last byte carries `rx_last`, and `pkt_done` with `pkt_len` set to the byte count is asserted in that same cycle.
- R8: A packet of zero, one or two bytes emits no `rx_valid`. It pulses `pkt_done` with `pkt_handshake` high and `pkt_len` equal to its byte count.
- R9: When byte MAX_BYTES+1 completes, reception aborts. `pkt_done` pulses with `pkt_overflow` and `pkt_len` = MAX_BYTES. The first MAX_BYTES-2 bytes have already been emitted, none of them with `rx_last`. A packet of exactly MAX_BYTES bytes is delivered normally.
- R10: During and right after reset, `rx_valid`, `rx_last`, `pkt_done` and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversample clock, OVS cycles per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_byte` holds a byte this cycle |
| rx_last | output | 1 | Byte is the packet's final byte |
| pkt_done | output | 1 | One-cycle end-of-packet report |
| pkt_len | output | clog2(MAX_BYTES+1) | Bytes received, valid with `pkt_done` |
| pkt_handshake | output | 1 | Packet shorter than three bytes |
| pkt_overflow | output | 1 | Packet exceeded MAX_BYTES |
| pkt_stuff_err | output | 1 | Stuffed position carried no transition |

## Verification
The bench builds the block with OVS = 8 and MAX_BYTES = 6. The small capacity lets an overflow packet of seven bytes, and the boundary packet of exactly six bytes, run in a few hundred bit times. With eight clocks per bit, each bit centre falls four clocks after a resynchronising edge. This makes the false-sync retreat, a dribble bit before SE0, and a stuffed bit right after the sync field's trailing 1 all land on exact, predictable cycles.

// File: rtl/lsusb_rx.sv
`timescale 1ns/1ps
module lsusb_rx #(
  parameter int OVS       = 8,
  parameter int MAX_BYTES = 11
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dp_i,
  input  logic                           dm_i,
  output logic [7:0]                     rx_byte,
  output logic                           rx_valid,
  output logic                           rx_last,
  output logic                           pkt_done,
  output logic [$clog2(MAX_BYTES+1)-1:0] pkt_len,
  output logic                           pkt_handshake,
  output logic                           pkt_overflow,
  output logic                           pkt_stuff_err
);

  localparam int LEN_W = $clog2(MAX_BYTES+1);
  localparam int PH_W  = $clog2(OVS);
  localparam logic [PH_W-1:0]  HALF    = PH_W'(OVS/2);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS-1);
  localparam logic [LEN_W-1:0] CAP     = LEN_W'(MAX_BYTES);

  typedef enum logic [2:0] {S_WAITJ, S_HUNT, S_SYNC, S_DATA, S_FLUSH, S_DRAIN} st_t;

  st_t              state;
  logic [1:0]       dp_ff, dm_ff;
  logic             dm_q;
  logic [PH_W-1:0]  ph;
  logic             first;
  logic             prev_lvl;
  logic [2:0]       ones;
  logic [2:0]       bitpos;
  logic [7:0]       sh;
  logic [7:0]       h0, h1;
  logic [LEN_W-1:0] cnt;

  wire dp_s     = dp_ff[1];
  wire dm_s     = dm_ff[1];
  wire trans    = dm_s ^ dm_q;
  wire line_j   = dm_s & ~dp_s;
  wire line_k   = ~dm_s & dp_s;
  wire line_se0 = ~dm_s & ~dp_s;

  wire [PH_W-1:0] ph_cur = trans ? '0 : ph;
  wire centre     = (ph_cur == HALF);
  wire nrzi_one   = (dm_s == prev_lvl);
  wire stuff_slot = (ones == 3'd6);
  wire eop_hit    = line_se0 && (bitpos != 3'd0);
  wire [7:0] byte_next = {nrzi_one, sh[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_ff <= 2'b00;
      dm_ff <= 2'b11;
      dm_q  <= 1'b1;
      ph    <= '0;
    end else begin
      dp_ff <= {dp_ff[0], dp_i};
      dm_ff <= {dm_ff[0], dm_i};
      dm_q  <= dm_s;
      ph    <= (ph_cur == PH_LAST) ? '0 : ph_cur + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_WAITJ;
      first         <= 1'b0;
      prev_lvl      <= 1'b0;
      ones          <= '0;
      bitpos        <= '0;
      sh            <= '0;
      h0            <= '0;
      h1            <= '0;
      cnt           <= '0;
      rx_byte       <= '0;
      rx_valid      <= 1'b0;
      rx_last       <= 1'b0;
      pkt_done      <= 1'b0;
      pkt_len       <= '0;
      pkt_handshake <= 1'b0;
      pkt_overflow  <= 1'b0;
      pkt_stuff_err <= 1'b0;
    end else begin
      rx_valid      <= 1'b0;
      rx_last       <= 1'b0;
      pkt_done      <= 1'b0;
      pkt_handshake <= 1'b0;
      pkt_overflow  <= 1'b0;
      pkt_stuff_err <= 1'b0;
      case (state)
        S_WAITJ: if (line_j) state <= S_HUNT;
        S_HUNT: begin
          if (trans && line_k) begin
            state <= S_SYNC;
            first <= 1'b1;
          end
        end
        S_SYNC: begin
          if (line_se0) begin
            state <= S_WAITJ;
          end else if (centre) begin
            if (!line_k) begin
              state <= S_HUNT;
            end else if (first) begin
              first <= 1'b0;
            end else begin
              state    <= S_DATA;
              prev_lvl <= 1'b0;
              ones     <= 3'd1;
              bitpos   <= '0;
              cnt      <= '0;
            end
          end
        end
        S_DATA: begin
          if (centre) begin
            if (eop_hit) begin
              if (cnt > LEN_W'(2)) begin
                rx_byte  <= h0;
                rx_valid <= 1'b1;
                state    <= S_FLUSH;
              end else begin
                pkt_done      <= 1'b1;
                pkt_handshake <= 1'b1;
                pkt_len       <= cnt;
                state         <= S_WAITJ;
              end
            end else begin
              prev_lvl <= dm_s;
              if (stuff_slot) begin
                if (nrzi_one) begin
                  pkt_done      <= 1'b1;
                  pkt_stuff_err <= 1'b1;
                  pkt_len       <= cnt;
                  state         <= S_DRAIN;
                end else begin
                  ones <= '0;
                end
              end else begin
                ones   <= nrzi_one ? ones + 3'd1 : 3'd0;
                sh     <= byte_next;
                bitpos <= bitpos + 3'd1;
                if (bitpos == 3'd7) begin
                  if (cnt == CAP) begin
                    pkt_done     <= 1'b1;
                    pkt_overflow <= 1'b1;
                    pkt_len      <= cnt;
                    state        <= S_DRAIN;
                  end else begin
                    cnt <= cnt + LEN_W'(1);
                    if (cnt == '0) begin
                      h0 <= byte_next;
                    end else if (cnt == LEN_W'(1)) begin
                      h1 <= byte_next;
                    end else begin
                      rx_byte  <= h0;
                      rx_valid <= 1'b1;
                      h0       <= h1;
                      h1       <= byte_next;
                    end
                  end
                end
              end
            end
          end
        end
        S_FLUSH: begin
          rx_byte  <= h1;
          rx_valid <= 1'b1;
          rx_last  <= 1'b1;
          pkt_done <= 1'b1;
          pkt_len  <= cnt;
          state    <= S_WAITJ;
        end
        S_DRAIN: if (line_se0) state <= S_WAITJ;
        default: state <= S_WAITJ;
      endcase
    end
  end

  p_last_has_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last |-> (rx_valid && pkt_done));
  p_single_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
  p_hs_no_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_handshake |-> (pkt_done && !rx_valid));
  p_len_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len <= CAP));
  p_ovf_no_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_overflow |-> !rx_last);
  p_one_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> ($countones({pkt_handshake, pkt_overflow, pkt_stuff_err}) <= 1));
  p_drain_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DRAIN) |-> !rx_valid);

endmodule

// File: tb/lsusb_rx_tb_top.sv
`timescale 1ns/1ps
module lsusb_rx_tb_top;
  localparam int OVS  = 8;
  localparam int MAXB = 6;
  localparam int LW   = $clog2(MAXB+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b1;
  logic [7:0] rx_byte;
  logic rx_valid, rx_last, pkt_done, pkt_handshake, pkt_overflow, pkt_stuff_err;
  logic [LW-1:0] pkt_len;

  always #2.5 clk = ~clk;

  lsusb_rx #(.OVS(OVS), .MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_last(rx_last),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .pkt_handshake(pkt_handshake),
    .pkt_overflow(pkt_overflow), .pkt_stuff_err(pkt_stuff_err));

  int nchk = 0, nfail = 0;
  bit mon_en = 1'b0, ended = 1'b0;
  string cur_req = "R10";
  logic [8:0] exp_b[$];
  logic [LW+2:0] exp_d[$];
  logic [8:0] mb;
  logic [LW+2:0] md;
  logic [7:0] pk [0:15];
  logic lvl;
  int ones;

  always @(negedge clk) begin
    if (mon_en) begin
      if (rx_valid) begin
        nchk++;
        if (exp_b.size() == 0) begin
          nfail++;
          $display("FAIL %s: byte %h last %b, expected none", cur_req, rx_byte, rx_last);
        end else begin
          mb = exp_b.pop_front();
          if ({rx_last, rx_byte} !== mb) begin
            nfail++;
            $display("FAIL %s: byte/last %h/%b, expected %h/%b", cur_req, rx_byte, rx_last, mb[7:0], mb[8]);
          end
        end
      end
      if (pkt_done) begin
        nchk++;
        if (exp_d.size() == 0) begin
          nfail++;
          $display("FAIL %s: report len %0d flags %b, expected none", cur_req, pkt_len,
                   {pkt_handshake, pkt_overflow, pkt_stuff_err});
        end else begin
          md = exp_d.pop_front();
          if ({pkt_len, pkt_handshake, pkt_overflow, pkt_stuff_err} !== md) begin
            nfail++;
            $display("FAIL %s: report len %0d flags %b, expected len %0d flags %b", cur_req,
                     pkt_len, {pkt_handshake, pkt_overflow, pkt_stuff_err}, md[LW+2:3], md[2:0]);
          end
        end
      end
    end
  end

  task automatic drive_bit(input logic l);
    dm = l; dp = ~l;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic enc_bit(input bit b, input bit stf);
    if (!b) lvl = ~lvl;
    drive_bit(lvl);
    if (b) ones++; else ones = 0;
    if (stf && ones == 6) begin
      lvl = ~lvl;
      drive_bit(lvl);
      ones = 0;
    end
  endtask

  task automatic send_pkt(input int n, input bit dribble, input bit stf);
    lvl = 1'b1; ones = 0;
    for (int i = 0; i < 8; i++) enc_bit(i == 7, 1'b1);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) enc_bit(pk[k][i], stf);
    if (dribble) enc_bit(1'b0, 1'b0);
    dm = 1'b0; dp = 1'b0;
    repeat (2*OVS) @(negedge clk);
    for (int i = 0; i < 4; i++) drive_bit(1'b1);
  endtask

  task automatic expect_good(input int n);
    if (n < 3) exp_d.push_back({LW'(n), 3'b100});
    else begin
      for (int i = 0; i < n; i++) exp_b.push_back({i == n-1, pk[i]});
      exp_d.push_back({LW'(n), 3'b000});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    nchk++;
    if ({rx_valid, rx_last, pkt_done, pkt_handshake, pkt_overflow, pkt_stuff_err} !== 6'b0) begin
      nfail++;
      $display("FAIL R10: outputs %b, expected 000000",
               {rx_valid, rx_last, pkt_done, pkt_handshake, pkt_overflow, pkt_stuff_err});
    end
    rst_n = 1'b1;
    mon_en = 1'b1;
    for (int i = 0; i < 4; i++) drive_bit(1'b1);

    cur_req = "R1/R3/R7";
    pk[0] = 8'hA5; pk[1] = 8'h3C; pk[2] = 8'h81;
    expect_good(3); send_pkt(3, 1'b0, 1'b1);

    cur_req = "R4";
    pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'h7E; pk[3] = 8'h00; pk[4] = 8'hFE;
    expect_good(5); send_pkt(5, 1'b0, 1'b1);

    cur_req = "R8";
    pk[0] = 8'hD2;
    expect_good(1); send_pkt(1, 1'b0, 1'b1);
    pk[0] = 8'h4B; pk[1] = 8'hFF;
    expect_good(2); send_pkt(2, 1'b0, 1'b1);

    cur_req = "R2";
    drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b1);
    pk[0] = 8'h11; pk[1] = 8'h22; pk[2] = 8'h33; pk[3] = 8'h44;
    expect_good(4); send_pkt(4, 1'b0, 1'b1);

    cur_req = "R6";
    pk[0] = 8'hC3; pk[1] = 8'h0F; pk[2] = 8'hF0; pk[3] = 8'h5A;
    expect_good(4); send_pkt(4, 1'b1, 1'b1);
    expect_good(0); send_pkt(0, 1'b0, 1'b1);

    cur_req = "R9";
    for (int i = 0; i < 7; i++) pk[i] = 8'(8'h31 + 8'(i) * 8'h17);
    expect_good(6); send_pkt(6, 1'b0, 1'b1);
    for (int i = 0; i < MAXB-2; i++) exp_b.push_back({1'b0, pk[i]});
    exp_d.push_back({LW'(MAXB), 3'b010});
    send_pkt(7, 1'b0, 1'b1);

    cur_req = "R5";
    pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'h12;
    exp_d.push_back({LW'(0), 3'b001});
    send_pkt(3, 1'b0, 1'b0);
    pk[0] = 8'hE1; pk[1] = 8'h2D; pk[2] = 8'h99;
    expect_good(3); send_pkt(3, 1'b0, 1'b1);

    repeat (4*OVS) @(negedge clk);
    cur_req = "R7";
    nchk++;
    if (exp_b.size() != 0 || exp_d.size() != 0) begin
      nfail++;
      $display("FAIL R7: %0d bytes and %0d reports outstanding, expected 0 and 0",
               exp_b.size(), exp_d.size());
    end
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule